// File: doc/BRIEF.md
# Seven-to-One Display Link Serializer

This block turns one parallel display word per pixel period into four serial lanes. The word has 21 bits: 18 bits of colour data, a line sync, a frame sync and a data-enable flag. Three data lanes each carry seven of those bits per pixel period. A fourth lane sends a fixed seven-slot clock pattern, so a receiver can recover the word boundary. Everything runs from one bit clock at seven times the pixel rate. An internal phase counter divides that clock down to the pixel rate. The block also drives a pixel clock out, and the pixel source launches its words against that clock. Pixel rates of 20 to 65 MHz need a bit clock of 140 to 455 MHz. The analog line drivers and the clock multiplier sit outside this block.

A static `edge_sel` input picks the capture point for the parallel word. With `edge_sel` low, the word is taken where the pixel clock rises. With `edge_sel` high, it is taken where the pixel clock falls. A captured word then moves into a hold register at a fixed phase. The hold register loads all four shifters on one edge, so a lane is never reloaded in the middle of a word.

The sequencer has three states:
- `ST_DOWN`: quiet, with everything cleared.
- `ST_PRIME`: the counter runs, but no word has been loaded yet.
- `ST_RUN`: words are streaming.

Its transitions are:
- wake: `ST_DOWN` to `ST_PRIME` when `pwr_dn` is low.
- first load: `ST_PRIME` to `ST_RUN` on the last phase of the period.
- sleep: from any state to `ST_DOWN` when `pwr_dn` is high.
- hold: every other case leaves the state unchanged.

Top module: `pixlink_ser7`

## Requirements
- R1: While `rst_n` is low, `data_lane`, `clk_lane` and `pix_clk_out` are all 0. The first pixel period after reset sends 0 on every lane.
- R2: `pix_clk_out` has a period of 7 bit clocks. It is high for the first 4 slots of each pixel period and low for the last 3. A pixel period starts where `pix_clk_out` rises.
- R3: Once running, `clk_lane` sends the slot sequence 1,1,0,0,0,1,1 in every pixel period. Its first slot is the one that starts at the `pix_clk_out` rise.
- R4: The word is packed as follows: `pix_rgb` is bits 0-17, `line_sync` is bit 18, `frame_sync` is bit 19 and `data_en` is bit 20. `data_lane[k]` carries bits 7k+6 down to 7k, with the highest-numbered bit in the first slot of the period.
- R5: With `edge_sel` = 0, the word is sampled at the bit-clock edge where `pix_clk_out` rises. It is sent in the pixel period that begins at the next rise after that one.
- R6: With `edge_sel` = 1, the word is sampled at the bit-clock edge where `pix_clk_out` falls. It is sent in the very next pixel period.
- R7: The first bit-clock edge that samples `pwr_dn` high forces all lanes and `pix_clk_out` to 0. They stay at 0 for as long as `pwr_dn` is high.
- R8: The first edge that samples `pwr_dn` low raises `pix_clk_out` and starts a pixel period. All lanes send 0 for that whole period. The clock pattern and the first captured word begin in the period after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bit_clk | input | 1 | Serial bit clock, 7x pixel rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_dn | input | 1 | Power-down request, sampled on bit_clk |
| edge_sel | input | 1 | Capture point: 0 = pixel clock rise, 1 = fall |
| pix_rgb | input | 18 | Colour data, word bits 0-17 |
| line_sync | input | 1 | Line sync, word bit 18 |
| frame_sync | input | 1 | Frame sync, word bit 19 |
| data_en | input | 1 | Data enable, word bit 20 |
| pix_clk_out | output | 1 | Generated pixel clock for the word source |
| data_lane | output | 3 | Serial data lanes |
| clk_lane | output | 1 | Serial forwarded-clock lane |

## Verification
The assertions check a fixed set of cycle-level rules on every cycle:
- Power-down silences every lane one edge after `pwr_dn` is sampled high.
- `pix_clk_out` always stays high for exactly four cycles before it falls.
- The clock lane falls only while the pixel clock is high.
- The clock lane rises only while the pixel clock is low or at the period start.

Only the bench's scenarios can show which word lands in which period. That covers the different latencies of the two capture points, the bit-to-lane packing and slot order, and the silent first period after wake-up.

// File: rtl/pixlink_pkg.sv
package pixlink_pkg;
    typedef enum logic [1:0] {
        ST_DOWN,
        ST_PRIME,
        ST_RUN
    } link_state_t;
endpackage

// File: rtl/pl_seq_ctrl.sv
module pl_seq_ctrl
    import pixlink_pkg::*;
#(
    parameter int BITS    = 7,
    parameter int HIGH_PH = 4,
    localparam int PW     = $clog2(BITS)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_dn,
    output logic pix_clk,
    output logic cap_rise,
    output logic cap_fall,
    output logic hold_en,
    output logic load_en,
    output logic clr
);
    link_state_t state, state_nx;
    logic [PW-1:0] ph;
    logic          last_ph;

    assign last_ph = (ph == PW'(BITS - 1));

    // phase counter: parked at 0 while quiet or being put to sleep
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ph <= '0;
        else if (pwr_dn || state == ST_DOWN)
            ph <= '0;
        else
            ph <= last_ph ? '0 : ph + 1'b1;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_DOWN;
        else
            state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_DOWN:  state_nx = pwr_dn ? ST_DOWN : ST_PRIME;
            ST_PRIME: state_nx = pwr_dn ? ST_DOWN : (last_ph ? ST_RUN : ST_PRIME);
            ST_RUN:   state_nx = pwr_dn ? ST_DOWN : ST_RUN;
        endcase
    end

    // outputs
    always_comb begin
        pix_clk  = 1'b0;
        cap_rise = 1'b0;
        cap_fall = 1'b0;
        hold_en  = 1'b0;
        load_en  = 1'b0;
        clr      = 1'b1;
        unique case (state)
            ST_DOWN: begin
                clr = 1'b1;
            end
            ST_PRIME, ST_RUN: begin
                clr      = pwr_dn;
                pix_clk  = (ph < PW'(HIGH_PH));
                cap_rise = last_ph;
                cap_fall = (ph == PW'(HIGH_PH - 1));
                hold_en  = (ph == PW'(BITS - 2));
                load_en  = last_ph;
            end
        endcase
    end
endmodule

// File: rtl/pl_word_capture.sv
module pl_word_capture #(
    parameter int W = 21
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         on_fall,
    input  logic         cap_rise,
    input  logic         cap_fall,
    input  logic         hold_en,
    input  logic [W-1:0] din,
    output logic [W-1:0] word_q
);
    logic [W-1:0] cap_q;
    logic         take;

    assign take = on_fall ? cap_fall : cap_rise;

    // first stage: sampled at the chosen pixel-clock edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cap_q <= '0;
        else if (clr)
            cap_q <= '0;
        else if (take)
            cap_q <= din;
    end

    // second stage: fixed phase, one slot before the shifters load
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            word_q <= '0;
        else if (clr)
            word_q <= '0;
        else if (hold_en)
            word_q <= cap_q;
    end
endmodule

// File: rtl/pl_lane_shifter.sv
module pl_lane_shifter #(
    parameter int BITS = 7
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            load,
    input  logic [BITS-1:0] pdata,
    output logic            sout
);
    logic [BITS-1:0] sreg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            sreg <= '0;
        else if (clr)
            sreg <= '0;
        else if (load)
            sreg <= pdata;
        else
            sreg <= {sreg[BITS-2:0], 1'b0};
    end

    assign sout = sreg[BITS-1];
endmodule

// File: rtl/pixlink_ser7.sv
module pixlink_ser7 #(
    parameter int RGB_W   = 18,
    parameter int BITS    = 7,
    parameter int HIGH_PH = 4,
    parameter logic [BITS-1:0] CLK_PAT = 7'b1100011,
    localparam int WORD_W = RGB_W + 3,
    localparam int LANES  = (WORD_W + BITS - 1) / BITS
) (
    input  logic             bit_clk,
    input  logic             rst_n,
    input  logic             pwr_dn,
    input  logic             edge_sel,
    input  logic [RGB_W-1:0] pix_rgb,
    input  logic             line_sync,
    input  logic             frame_sync,
    input  logic             data_en,
    output logic             pix_clk_out,
    output logic [LANES-1:0] data_lane,
    output logic             clk_lane
);
    localparam int PACK_W = LANES * BITS;

    logic              cap_rise, cap_fall, hold_en, load_en, clr;
    logic [PACK_W-1:0] word_in, word_q;

    always_comb begin
        word_in = '0;
        word_in[WORD_W-1:0] = {data_en, frame_sync, line_sync, pix_rgb};
    end

    pl_seq_ctrl #(.BITS(BITS), .HIGH_PH(HIGH_PH)) u_ctrl (
        .clk      (bit_clk),
        .rst_n    (rst_n),
        .pwr_dn   (pwr_dn),
        .pix_clk  (pix_clk_out),
        .cap_rise (cap_rise),
        .cap_fall (cap_fall),
        .hold_en  (hold_en),
        .load_en  (load_en),
        .clr      (clr)
    );

    pl_word_capture #(.W(PACK_W)) u_cap (
        .clk      (bit_clk),
        .rst_n    (rst_n),
        .clr      (clr),
        .on_fall  (edge_sel),
        .cap_rise (cap_rise),
        .cap_fall (cap_fall),
        .hold_en  (hold_en),
        .din      (word_in),
        .word_q   (word_q)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        pl_lane_shifter #(.BITS(BITS)) u_sh (
            .clk   (bit_clk),
            .rst_n (rst_n),
            .clr   (clr),
            .load  (load_en),
            .pdata (word_q[g*BITS +: BITS]),
            .sout  (data_lane[g])
        );
    end

    pl_lane_shifter #(.BITS(BITS)) u_clk_sh (
        .clk   (bit_clk),
        .rst_n (rst_n),
        .clr   (clr),
        .load  (load_en),
        .pdata (CLK_PAT),
        .sout  (clk_lane)
    );
endmodule

// File: rtl/pixlink_ser7_chk.sv
module pixlink_ser7_chk #(
    parameter int LANES   = 3,
    parameter int HIGH_PH = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pwr_dn,
    input logic             pix_clk_out,
    input logic [LANES-1:0] data_lane,
    input logic             clk_lane
);
    logic [3:0] hi_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            hi_cnt <= '0;
        else if (!pix_clk_out)
            hi_cnt <= '0;
        else if (hi_cnt != 4'hF)
            hi_cnt <= hi_cnt + 1'b1;
    end

    a_r7_pd_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_dn |=> (data_lane == '0 && !clk_lane && !pix_clk_out));

    a_r2_high_run: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(pix_clk_out) && !$past(pwr_dn)) |-> (hi_cnt == 4'(HIGH_PH)));

    a_r3_clk_fall_in_high: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(clk_lane) && !$past(pwr_dn)) |-> pix_clk_out);

    a_r3_clk_rise_in_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clk_lane) |-> (!pix_clk_out || $rose(pix_clk_out)));
endmodule

bind pixlink_ser7 pixlink_ser7_chk #(.LANES(LANES), .HIGH_PH(HIGH_PH)) u_chk (
    .clk         (bit_clk),
    .rst_n       (rst_n),
    .pwr_dn      (pwr_dn),
    .pix_clk_out (pix_clk_out),
    .data_lane   (data_lane),
    .clk_lane    (clk_lane)
);

// File: tb/pixlink_ser7_test.sv
module pixlink_ser7_test;
    logic        bit_clk = 1'b0;
    logic        rst_n = 1'b0, pwr_dn = 1'b0, edge_sel = 1'b0;
    logic [17:0] pix_rgb = '0;
    logic        line_sync = 1'b0, frame_sync = 1'b0, data_en = 1'b0;
    logic        pix_clk_out, clk_lane;
    logic [2:0]  data_lane;
    int          checks = 0, fails = 0;

    always #4 bit_clk = ~bit_clk;

    pixlink_ser7 uut (
        .bit_clk(bit_clk), .rst_n(rst_n), .pwr_dn(pwr_dn), .edge_sel(edge_sel),
        .pix_rgb(pix_rgb), .line_sync(line_sync), .frame_sync(frame_sync),
        .data_en(data_en), .pix_clk_out(pix_clk_out), .data_lane(data_lane),
        .clk_lane(clk_lane)
    );

    // port monitor: frames collected from pixel-clock rise to rise
    int         bph = 0, lo_run = 0, frames = 0;
    bit         synced = 0, prev_p = 0;
    logic [6:0] a0, a1, a2, ac, ap;
    logic [20:0] fr_word;
    logic [6:0]  fr_clk, fr_pclk;

    always @(negedge bit_clk) begin
        if (pix_clk_out && !prev_p) begin
            bph = 0;
            synced = 1;
        end else begin
            bph = (bph >= 6) ? 0 : bph + 1;
        end
        lo_run = pix_clk_out ? 0 : lo_run + 1;
        if (lo_run >= 4) synced = 0;
        prev_p = pix_clk_out;
        if (bph == 0) begin
            a0 = {6'b0, data_lane[0]}; a1 = {6'b0, data_lane[1]};
            a2 = {6'b0, data_lane[2]}; ac = {6'b0, clk_lane};
            ap = {6'b0, pix_clk_out};
        end else begin
            a0 = {a0[5:0], data_lane[0]}; a1 = {a1[5:0], data_lane[1]};
            a2 = {a2[5:0], data_lane[2]}; ac = {ac[5:0], clk_lane};
            ap = {ap[5:0], pix_clk_out};
        end
        if (bph == 6 && synced) begin
            fr_word = {a2, a1, a0};
            fr_clk  = ac;
            fr_pclk = ap;
            frames++;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic set_word(input logic [20:0] w);
        {data_en, frame_sync, line_sync, pix_rgb} = w;
    endtask

    task automatic wait_frames(input int n);
        int target;
        target = frames + n;
        while (frames < target) @(posedge bit_clk);
    endtask

    // returns one step into the second slot of a pixel period
    task automatic at_slot1();
        do begin
            @(posedge bit_clk);
            #1;
        end while (!(bph == 0 && synced));
    endtask

    task automatic test_reset();
        logic any;
        any = 0;
        repeat (3) begin
            @(negedge bit_clk);
            any = any | pix_clk_out | clk_lane | (|data_lane);
        end
        chk("R1 outputs low in reset", any, 0);
        @(posedge bit_clk); #1 rst_n = 1'b1;
        wait_frames(1);
        chk("R1 first period data", fr_word, 0);
        chk("R1 first period clock lane", fr_clk, 0);
    endtask

    task automatic test_clock_shape();
        for (int i = 0; i < 3; i++) begin
            wait_frames(1);
            chk("R2 pixel clock slots", fr_pclk, 7'b1111000);
            chk("R3 clock lane pattern", fr_clk, 7'b1100011);
        end
    endtask

    task automatic test_mapping();
        logic [20:0] pats [5];
        pats[0] = 21'h1FFFFF;
        pats[1] = 21'h155555;
        pats[2] = 21'h0A1B2C;
        pats[3] = 21'h100000;
        pats[4] = 21'h040000;
        for (int i = 0; i < 5; i++) begin
            set_word(pats[i]);
            wait_frames(3);
            chk("R4 lane packing", fr_word, pats[i]);
        end
        // data_en alone: lane 2 first slot; line_sync alone: lane 2 third slot
        set_word(21'h100000);
        wait_frames(3);
        chk("R4 data_en first slot lane 2", fr_word[20:14], 7'b1000000);
        set_word(21'h040000);
        wait_frames(3);
        chk("R4 line_sync third slot lane 2", fr_word[20:14], 7'b0010000);
    endtask

    task automatic test_edge(input logic fall);
        int f0;
        edge_sel = fall;
        set_word(21'h0F0F0F);
        wait_frames(4);
        at_slot1();
        set_word(21'h12345A);
        f0 = frames;
        while (frames < f0 + 2) @(posedge bit_clk);
        if (fall) chk("R6 falling capture next period", fr_word, 21'h12345A);
        else      chk("R5 rising capture old word", fr_word, 21'h0F0F0F);
        while (frames < f0 + 3) @(posedge bit_clk);
        if (fall) chk("R6 word held", fr_word, 21'h12345A);
        else      chk("R5 rising capture one period later", fr_word, 21'h12345A);
    endtask

    task automatic test_power();
        logic any;
        int   fw;
        edge_sel = 1'b1;
        set_word(21'h1C3A55);
        wait_frames(4);
        @(posedge bit_clk); #1 pwr_dn = 1'b1;
        @(posedge bit_clk);
        any = 0;
        repeat (14) begin
            @(negedge bit_clk);
            any = any | pix_clk_out | clk_lane | (|data_lane);
        end
        chk("R7 all lanes quiet in power-down", any, 0);
        fw = frames;
        @(posedge bit_clk); #1 pwr_dn = 1'b0;
        while (frames < fw + 1) @(posedge bit_clk);
        chk("R8 first wake period data", fr_word, 0);
        chk("R8 first wake period clock lane", fr_clk, 0);
        chk("R8 first wake pixel clock", fr_pclk, 7'b1111000);
        while (frames < fw + 2) @(posedge bit_clk);
        chk("R8 clock lane starts clean", fr_clk, 7'b1100011);
        chk("R8 first word after wake", fr_word, 21'h1C3A55);
    endtask

    initial begin
        repeat (100000) @(posedge bit_clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        test_reset();
        test_clock_shape();
        test_mapping();
        test_edge(1'b0);
        test_edge(1'b1);
        test_power();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule